// File: doc/BRIEF.md
# Dual-Direction Universal Bus Transceiver Datapath

This block moves data between an A port and a B port. The default build is 18 bits wide, split into two 9-bit halves. Each direction has its own storage element for each half. That element can pass data straight through, keep the last value it accepted, or take a new value on a rising edge of a capture clock. A per-direction latch-enable level chooses between these behaviours. An active-low output enable per half decides whether the receiving port is driven. Each port is modelled with separate input, output and per-bit enable vectors instead of inout nets.

The two halves can run with separate controls. They can also be joined so that the half-0 control pins govern the whole word. Capture clocks, latch enables and data are sampled on the system clock `clk`. A capture-clock rising edge is seen when the clock is sampled low on one `clk` edge and high on the next.

A scan controller can assert `test_mode`. While it is high, the port outputs and enables come from boundary-cell values. The stored data is frozen, so normal traffic picks up again where it stopped.

Top module: `ubt_xcvr`

## Requirements
- R1: With `test_mode` low and the selected latch enable high, each output bit of the receiving port equals the matching input bit in the same cycle, with no register in the path.
- R2: With the latch enable low, a capture-clock rising edge (sampled 0 then 1 on consecutive `clk` edges) stores the input sampled on the second of those edges. The stored value appears on the output from the next cycle.
- R3: With the latch enable low and no capture-clock rising edge, the output keeps its stored value. When the enable falls, the stored value is the input sampled on the last `clk` edge at which the enable was still high.
- R4: Output enables are active low and apply per half: index 0 covers bits [8:0] and index 1 covers bits [17:9]. A high enable drives every `*_oe` bit of that half to 0. A low enable drives them all to 1.
- R5: B-to-A flow uses `le_ba`, `clk_ba` and `oe_ba_n` and behaves exactly like A-to-B flow.
- R6: With `join_halves` = 0, each half follows only its own control index and ignores the controls of the other half.
- R7: With `join_halves` = 1, control index 0 governs both halves and every control at index 1 has no effect.
- R8: Reset clears all stored data to 0. A capture clock that is already high when reset is released is not treated as a rising edge.
- R9: With `test_mode` high, `a_out` and `b_out` equal `tst_a_data` and `tst_b_data`. The enables of each half equal the inverse of `tst_oe_ab_n` / `tst_oe_ba_n`, whatever the normal controls are.
- R10: While `test_mode` is high, no stored value changes. After the mode is left with the latch enable low and no capture edge, the output shows the value held before test mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System sampling clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| join_halves | input | 1 | 1: control index 0 governs both halves |
| test_mode | input | 1 | Boundary values override outputs and freeze storage |
| a_in | input | 18 | A-port input data |
| b_in | input | 18 | B-port input data |
| oe_ab_n | input | 2 | Active-low B-output enable, per half |
| le_ab | input | 2 | A-to-B latch enable, per half |
| clk_ab | input | 2 | A-to-B capture clock, per half |
| oe_ba_n | input | 2 | Active-low A-output enable, per half |
| le_ba | input | 2 | B-to-A latch enable, per half |
| clk_ba | input | 2 | B-to-A capture clock, per half |
| tst_a_data | input | 18 | Boundary value for A outputs in test mode |
| tst_b_data | input | 18 | Boundary value for B outputs in test mode |
| tst_oe_ab_n | input | 2 | Boundary active-low B enables in test mode |
| tst_oe_ba_n | input | 2 | Boundary active-low A enables in test mode |
| b_out | output | 18 | B-port output data |
| b_oe | output | 18 | B-port per-bit drive enable |
| a_out | output | 18 | A-port output data |
| a_oe | output | 18 | A-port per-bit drive enable |

## Verification
Three kinds of stimulus separate the three storage behaviours.

- **Pass-through:** input data changes every cycle while the enable is high. A registered path would show up here as a one-cycle lag.
- **Hold:** input data changes while the enable is low and the capture clock is idle. This exposes any leak of new data into a held value.
- **Capture:** the capture clock toggles with fresh data each cycle. This pins down on which sample an edge stores data.

Further patterns cover the halves and the override:

- **Split halves:** the two halves get different controls, which catches cross-wiring.
- **Joined halves:** the index-1 controls are scrambled while the halves are joined, which shows whether index 1 still has any influence.
- **Test mode:** the capture clocks toggle and the enables are high during test mode. Comparing the output before entry and after exit then shows whether storage was frozen.

// File: rtl/ubt_pkg.sv
package ubt_pkg;

    // Action a storage cell takes on the coming clk edge
    typedef enum logic [1:0] {
        CELL_HOLD   = 2'd0,   // keep stored value
        CELL_PASS   = 2'd1,   // enable high: follow input
        CELL_STORE  = 2'd2,   // enable low, capture-clock rising edge
        CELL_FROZEN = 2'd3    // test mode: no update
    } cell_act_e;

endpackage

// File: rtl/ubt_lane.sv
module ubt_lane #(
    parameter int W = 9
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         le,
    input  logic         cap_clk,
    input  logic         freeze,
    input  logic [W-1:0] d_in,
    output logic [W-1:0] q
);
    import ubt_pkg::*;

    logic         cap_prev;
    logic         cap_rise;
    logic [W-1:0] hold;
    cell_act_e    act;

    assign cap_rise = cap_clk & ~cap_prev;

    // Classify this cycle's action
    always_comb begin
        if (freeze)        act = CELL_FROZEN;
        else if (le)       act = CELL_PASS;
        else if (cap_rise) act = CELL_STORE;
        else               act = CELL_HOLD;
    end

    // Capture-clock history; reset high so a clock already high is no edge
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cap_prev <= 1'b1;
        else        cap_prev <= cap_clk;
    end

    // Storage register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            hold <= '0;
        end else begin
            unique case (act)
                CELL_PASS, CELL_STORE: hold <= d_in;
                CELL_HOLD, CELL_FROZEN: hold <= hold;
                default:               hold <= hold;
            endcase
        end
    end

    // Transparent path when enabled, stored value otherwise
    always_comb begin
        q = le ? d_in : hold;
    end

endmodule

// File: rtl/ubt_dir.sv
module ubt_dir #(
    parameter int HALF_W = 9,
    parameter int HALVES = 2,
    localparam int N = HALF_W * HALVES
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              join_halves,
    input  logic              test_mode,
    input  logic [N-1:0]      d_in,
    input  logic [HALVES-1:0] oe_n,
    input  logic [HALVES-1:0] le,
    input  logic [HALVES-1:0] cap_clk,
    input  logic [N-1:0]      tst_data,
    input  logic [HALVES-1:0] tst_oe_n,
    output logic [N-1:0]      q,
    output logic [N-1:0]      oe
);
    for (genvar h = 0; h < HALVES; h++) begin : g_half
        logic              le_sel;
        logic              cap_sel;
        logic              oe_n_sel;
        logic [HALF_W-1:0] lane_q;

        // Joined halves take their controls from index 0
        assign le_sel   = join_halves ? le[0]      : le[h];
        assign cap_sel  = join_halves ? cap_clk[0] : cap_clk[h];
        assign oe_n_sel = join_halves ? oe_n[0]    : oe_n[h];

        ubt_lane #(.W(HALF_W)) u_lane (
            .clk     (clk),
            .rst_n   (rst_n),
            .le      (le_sel),
            .cap_clk (cap_sel),
            .freeze  (test_mode),
            .d_in    (d_in[h*HALF_W +: HALF_W]),
            .q       (lane_q)
        );

        // Boundary override
        assign q[h*HALF_W +: HALF_W]  = test_mode ? tst_data[h*HALF_W +: HALF_W] : lane_q;
        assign oe[h*HALF_W +: HALF_W] = {HALF_W{test_mode ? ~tst_oe_n[h] : ~oe_n_sel}};
    end

endmodule

// File: rtl/ubt_xcvr.sv
module ubt_xcvr #(
    parameter int HALF_W = 9,
    parameter int HALVES = 2,
    localparam int N = HALF_W * HALVES
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              join_halves,
    input  logic              test_mode,
    input  logic [N-1:0]      a_in,
    input  logic [N-1:0]      b_in,
    input  logic [HALVES-1:0] oe_ab_n,
    input  logic [HALVES-1:0] le_ab,
    input  logic [HALVES-1:0] clk_ab,
    input  logic [HALVES-1:0] oe_ba_n,
    input  logic [HALVES-1:0] le_ba,
    input  logic [HALVES-1:0] clk_ba,
    input  logic [N-1:0]      tst_a_data,
    input  logic [N-1:0]      tst_b_data,
    input  logic [HALVES-1:0] tst_oe_ab_n,
    input  logic [HALVES-1:0] tst_oe_ba_n,
    output logic [N-1:0]      b_out,
    output logic [N-1:0]      b_oe,
    output logic [N-1:0]      a_out,
    output logic [N-1:0]      a_oe
);
    // A to B
    ubt_dir #(.HALF_W(HALF_W), .HALVES(HALVES)) u_ab (
        .clk         (clk),
        .rst_n       (rst_n),
        .join_halves (join_halves),
        .test_mode   (test_mode),
        .d_in        (a_in),
        .oe_n        (oe_ab_n),
        .le          (le_ab),
        .cap_clk     (clk_ab),
        .tst_data    (tst_b_data),
        .tst_oe_n    (tst_oe_ab_n),
        .q           (b_out),
        .oe          (b_oe)
    );

    // B to A
    ubt_dir #(.HALF_W(HALF_W), .HALVES(HALVES)) u_ba (
        .clk         (clk),
        .rst_n       (rst_n),
        .join_halves (join_halves),
        .test_mode   (test_mode),
        .d_in        (b_in),
        .oe_n        (oe_ba_n),
        .le          (le_ba),
        .cap_clk     (clk_ba),
        .tst_data    (tst_a_data),
        .tst_oe_n    (tst_oe_ba_n),
        .q           (a_out),
        .oe          (a_oe)
    );

endmodule

// File: rtl/ubt_xcvr_chk.sv
module ubt_xcvr_chk #(
    parameter int HALF_W = 9,
    parameter int HALVES = 2,
    localparam int N = HALF_W * HALVES
) (
    input logic              clk,
    input logic              rst_n,
    input logic              test_mode,
    input logic              join_halves,
    input logic [N-1:0]      a_in,
    input logic [N-1:0]      b_in,
    input logic [HALVES-1:0] le_ab,
    input logic              le_ba0,
    input logic              clk_ab0,
    input logic              oe_ab_n_hi,
    input logic [N-1:0]      tst_a_data,
    input logic [N-1:0]      tst_b_data,
    input logic [N-1:0]      a_out,
    input logic [N-1:0]      b_out,
    input logic [HALF_W-1:0] b_oe_hi
);
    logic past_ok;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) past_ok <= 1'b0;
        else        past_ok <= 1'b1;
    end

    assert_pass_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (!test_mode && join_halves && le_ab[0]) |-> (b_out == a_in));

    assert_store_R2: assert property (@(posedge clk) disable iff (!rst_n || !past_ok)
        (!test_mode && !join_halves && !le_ab[0] && $rose(clk_ab0))
        |=> (test_mode || join_halves || le_ab[0] || b_out[HALF_W-1:0] == $past(a_in[HALF_W-1:0])));

    assert_hold_R3: assert property (@(posedge clk) disable iff (!rst_n || !past_ok)
        ($past(!le_ab[0] && !clk_ab0 && !test_mode && !join_halves)
         && !le_ab[0] && !test_mode && !join_halves)
        |-> (b_out[HALF_W-1:0] == $past(b_out[HALF_W-1:0])));

    assert_hiz_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (!test_mode && !join_halves && oe_ab_n_hi) |-> (b_oe_hi == '0));

    assert_rev_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (!test_mode && join_halves && le_ba0) |-> (a_out == b_in));

    assert_half_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (!test_mode && !join_halves && le_ab[HALVES-1])
        |-> (b_out[N-1 -: HALF_W] == a_in[N-1 -: HALF_W]));

    assert_override_R9: assert property (@(posedge clk) disable iff (!rst_n)
        test_mode |-> (a_out == tst_a_data && b_out == tst_b_data));

endmodule

bind ubt_xcvr ubt_xcvr_chk #(.HALF_W(HALF_W), .HALVES(HALVES)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .test_mode   (test_mode),
    .join_halves (join_halves),
    .a_in        (a_in),
    .b_in        (b_in),
    .le_ab       (le_ab),
    .le_ba0      (le_ba[0]),
    .clk_ab0     (clk_ab[0]),
    .oe_ab_n_hi  (oe_ab_n[HALVES-1]),
    .tst_a_data  (tst_a_data),
    .tst_b_data  (tst_b_data),
    .a_out       (a_out),
    .b_out       (b_out),
    .b_oe_hi     (b_oe[N-1 -: HALF_W])
);

// File: tb/tb_ubt_xcvr.sv
`timescale 1ns/1ps
module tb_ubt_xcvr;
    localparam int HW = 9;
    localparam int N  = 18;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          join_halves = 1'b0, test_mode = 1'b0;
    logic [N-1:0]  a_in = '0, b_in = '0, tst_a_data = '0, tst_b_data = '0;
    logic [1:0]    oe_ab_n = '0, le_ab = '0, clk_ab = 2'b11;
    logic [1:0]    oe_ba_n = '0, le_ba = '0, clk_ba = 2'b11;
    logic [1:0]    tst_oe_ab_n = '0, tst_oe_ba_n = '0;
    logic [N-1:0]  b_out, b_oe, a_out, a_oe;

    int    checks = 0;
    int    errors = 0;
    bit    done = 0;
    string phase = "R8 reset";

    // Behavioural reference state
    logic [HW-1:0] m_ab [2] = '{default: '0};
    logic [HW-1:0] m_ba [2] = '{default: '0};
    logic          p_ab [2] = '{default: 1'b1};
    logic          p_ba [2] = '{default: 1'b1};

    always #4 clk = ~clk;

    ubt_xcvr dut (
        .clk(clk), .rst_n(rst_n), .join_halves(join_halves), .test_mode(test_mode),
        .a_in(a_in), .b_in(b_in), .oe_ab_n(oe_ab_n), .le_ab(le_ab), .clk_ab(clk_ab),
        .oe_ba_n(oe_ba_n), .le_ba(le_ba), .clk_ba(clk_ba),
        .tst_a_data(tst_a_data), .tst_b_data(tst_b_data),
        .tst_oe_ab_n(tst_oe_ab_n), .tst_oe_ba_n(tst_oe_ba_n),
        .b_out(b_out), .b_oe(b_oe), .a_out(a_out), .a_oe(a_oe)
    );

    always @(posedge clk) begin
        for (int h = 0; h < 2; h++) begin
            int  c;
            bit  e_ab, e_ba;
            c = join_halves ? 0 : h;
            if (!rst_n) begin
                m_ab[h] = '0; m_ba[h] = '0; p_ab[h] = 1'b1; p_ba[h] = 1'b1;
            end else begin
                e_ab = clk_ab[c] && !p_ab[h];
                e_ba = clk_ba[c] && !p_ba[h];
                p_ab[h] = clk_ab[c];
                p_ba[h] = clk_ba[c];
                if (!test_mode) begin
                    if (le_ab[c] || e_ab) m_ab[h] = a_in[h*HW +: HW];
                    if (le_ba[c] || e_ba) m_ba[h] = b_in[h*HW +: HW];
                end
            end
        end
    end

    task automatic check(input string tag, input logic [N-1:0] act, input logic [N-1:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic compare();
        logic [N-1:0] eb, eboe, ea, eaoe;
        for (int h = 0; h < 2; h++) begin
            int c;
            c = join_halves ? 0 : h;
            eb[h*HW +: HW]   = test_mode ? tst_b_data[h*HW +: HW] : (le_ab[c] ? a_in[h*HW +: HW] : m_ab[h]);
            ea[h*HW +: HW]   = test_mode ? tst_a_data[h*HW +: HW] : (le_ba[c] ? b_in[h*HW +: HW] : m_ba[h]);
            eboe[h*HW +: HW] = {HW{test_mode ? ~tst_oe_ab_n[h] : ~oe_ab_n[c]}};
            eaoe[h*HW +: HW] = {HW{test_mode ? ~tst_oe_ba_n[h] : ~oe_ba_n[c]}};
        end
        check({phase, " b_out"}, b_out, eb);
        check({phase, " b_oe"},  b_oe,  eboe);
        check({phase, " a_out"}, a_out, ea);
        check({phase, " a_oe"},  a_oe,  eaoe);
    endtask

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
        compare();
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [N-1:0] last_a, pre_b, pre_a;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        // R8: clocks high at release, enables low -> outputs stay 0
        a_in = 18'h2a5a5; b_in = 18'h15a5a;
        tick(); tick();
        check("R8 reset b_out zero", b_out, '0);
        check("R8 reset a_out zero", a_out, '0);
        clk_ab = 2'b00; clk_ba = 2'b00;
        tick();

        phase = "R1 transparent";
        le_ab = 2'b11; le_ba = 2'b11;
        for (int i = 0; i < 6; i++) begin
            a_in = N'($urandom); b_in = N'($urandom); tick();
        end

        phase = "R3 hold";
        last_a = a_in;
        le_ab = 2'b00; le_ba = 2'b00;
        for (int i = 0; i < 5; i++) begin
            a_in = N'($urandom); b_in = N'($urandom); tick();
        end
        check("R3 held value", b_out, last_a);

        phase = "R2 clocked";
        for (int i = 0; i < 8; i++) begin
            clk_ab = ~clk_ab; a_in = N'($urandom); tick();
        end

        phase = "R4 enable";
        for (int i = 0; i < 4; i++) begin
            oe_ab_n = 2'(i); tick();
        end
        oe_ab_n = 2'b00;

        phase = "R5 reverse";
        le_ba = 2'b11;
        for (int i = 0; i < 3; i++) begin b_in = N'($urandom); tick(); end
        le_ba = 2'b00;
        for (int i = 0; i < 6; i++) begin
            clk_ba = ~clk_ba; b_in = N'($urandom); tick();
        end
        for (int i = 0; i < 4; i++) begin oe_ba_n = 2'(i); tick(); end
        oe_ba_n = 2'b00;

        phase = "R6 split";
        le_ab = 2'b01; clk_ab = 2'b00; oe_ab_n = 2'b10;
        for (int i = 0; i < 8; i++) begin
            clk_ab[1] = ~clk_ab[1]; a_in = N'($urandom); tick();
        end
        le_ab = 2'b10; oe_ab_n = 2'b01;
        for (int i = 0; i < 6; i++) begin
            clk_ab[0] = ~clk_ab[0]; a_in = N'($urandom); tick();
        end

        phase = "R7 joined";
        join_halves = 1'b1; le_ab = 2'b00; clk_ab = 2'b00; oe_ab_n = 2'b00;
        for (int i = 0; i < 12; i++) begin
            le_ab[1] = 1'($urandom); oe_ab_n[1] = 1'($urandom); clk_ab[1] = 1'($urandom);
            le_ba[1] = 1'($urandom); clk_ba[1] = 1'($urandom); oe_ba_n[1] = 1'($urandom);
            if (i % 3 == 0) clk_ab[0] = ~clk_ab[0];
            le_ab[0] = (i > 8);
            a_in = N'($urandom); b_in = N'($urandom); tick();
        end
        join_halves = 1'b0;

        phase = "R9 test override";
        le_ab = 2'b00; le_ba = 2'b00; clk_ab = 2'b00; clk_ba = 2'b00;
        oe_ab_n = 2'b00; oe_ba_n = 2'b00;
        tick();
        pre_b = b_out; pre_a = a_out;
        test_mode = 1'b1;
        for (int i = 0; i < 8; i++) begin
            tst_a_data = N'($urandom); tst_b_data = N'($urandom);
            tst_oe_ab_n = 2'(i); tst_oe_ba_n = 2'(i + 1);
            le_ab = 2'(i); clk_ab = ~clk_ab; clk_ba = ~clk_ba; le_ba = 2'(i >> 1);
            a_in = N'($urandom); b_in = N'($urandom); tick();
        end
        phase = "R10 freeze";
        test_mode = 1'b0; le_ab = 2'b00; le_ba = 2'b00; clk_ab = 2'b00; clk_ba = 2'b00;
        tick(); tick();
        check("R10 b held across test", b_out, pre_b);
        check("R10 a held across test", a_out, pre_a);

        phase = "R2 mixed";
        for (int i = 0; i < 40; i++) begin
            join_halves = 1'($urandom); le_ab = 2'($urandom); le_ba = 2'($urandom);
            clk_ab = 2'($urandom); clk_ba = 2'($urandom);
            oe_ab_n = 2'($urandom); oe_ba_n = 2'($urandom);
            a_in = N'($urandom); b_in = N'($urandom); tick();
        end

        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule